// File: doc/BRIEF.md
# Event-Driven Up/Down Counter with Match Taps

This block is a wide binary counter driven from a single clock. It counts up or down while running. It also reacts to a one-cycle event input by doing one of four things to its value: replacing it, adding an operand, subtracting an operand, or shifting it by one bit. In the cycle where the event acts, normal counting does not happen.

Three registered flags describe the counter value from the previous cycle. One flag reports that the value is zero. The other two report equality with two match references. Each match flag can be switched into tap mode, where it follows a single selected bit of the counter instead of the compare. An external controller can write the counter or either match reference through one shared load bus and three separate strobes.

A typical use is as a timing or sequencing element inside a larger logic fabric. The match and tap flags feed downstream state machines, and the controller re-arms the match references on the fly.

Top module: `evt_counter`

## Requirements
- R1: A synchronous `rst` clears the counter and both match references and sets all three flags to 1. Reset takes effect at the next rising edge.
- R2: When `run_en`=1 and `count_up`=1 and nothing of higher priority acts, the counter increments by one per cycle and wraps from all-ones to zero. When `run_en`=0, the counter holds its value.
- R3: When `run_en`=1 and `count_up`=0 and nothing of higher priority acts, the counter decrements by one per cycle and wraps from zero to all-ones.
- R4: `zero_flag` is 1 exactly when the counter value one cycle earlier was zero.
- R5: When its tap mode is off, `m1_flag` (or `m2_flag`) is 1 exactly when, one cycle earlier, the counter equalled match reference 1 (or 2).
- R6: When `tap1_en` (or `tap2_en`) is 1, `m1_flag` (or `m2_flag`) equals the counter bit selected by `tap1_idx` (or `tap2_idx`) one cycle earlier. Index 0 is the least significant bit.
- R7: When `glb_en`=1, `ld_cnt` loads `ext_val` into the counter, `ld_m1` loads it into match reference 1, and `ld_m2` loads it into match reference 2. The three strobes may be combined in one cycle.
- R8: When an event occurs with `evt_is_load`=1, the counter takes `evt_val`. Events act whatever `run_en` is.
- R9: When an event occurs with `evt_is_load`=0 and `evt_arith`=1, the counter becomes counter+`evt_val` if `evt_dir`=1, or counter−`evt_val` if `evt_dir`=0. Both results are taken modulo 2^W.
- R10: When an event occurs with `evt_is_load`=0 and `evt_arith`=0, the counter shifts one bit left if `evt_dir`=1, or one bit right if `evt_dir`=0. The vacated bit is filled with zero.
- R11: For the counter value, the priority is: `cnt_rst` (clears the counter only), then `ld_cnt`, then the event action, then counting.
- R12: When `glb_en`=0, the counter and both match references hold their values. The strobes, the event and counting are ignored. `rst` and `cnt_rst` still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global reset, active high |
| cnt_rst | input | 1 | Synchronous clear of the counter value only |
| glb_en | input | 1 | Global enable for every state change except the resets |
| run_en | input | 1 | 1 lets the counter count each cycle |
| count_up | input | 1 | Count direction: 1 up, 0 down |
| evt | input | 1 | Event strobe |
| evt_is_load | input | 1 | Event action: 1 load, 0 arithmetic or shift |
| evt_arith | input | 1 | Non-load event: 1 add/subtract, 0 shift |
| evt_dir | input | 1 | 1 add or shift left, 0 subtract or shift right |
| evt_val | input | W (32) | Event load value and add/subtract operand |
| tap1_en | input | 1 | Tap mode for match flag 1 |
| tap1_idx | input | log2(W) (5) | Counter bit tapped by match flag 1 |
| tap2_en | input | 1 | Tap mode for match flag 2 |
| tap2_idx | input | log2(W) (5) | Counter bit tapped by match flag 2 |
| ext_val | input | W (32) | Shared external load value |
| ld_cnt | input | 1 | Load strobe for the counter |
| ld_m1 | input | 1 | Load strobe for match reference 1 |
| ld_m2 | input | 1 | Load strobe for match reference 2 |
| cnt_val | output | W (32) | Current counter value |
| zero_flag | output | 1 | Registered zero flag |
| m1_flag | output | 1 | Registered match/tap flag 1 |
| m2_flag | output | 1 | Registered match/tap flag 2 |

## Verification
Directed sequences cover both wrap points in each counting direction, to separate modulo wrap from saturation. They also cover every event variant on values chosen so that add and subtract overflow and so that shifts drop a set bit at each end; this exposes wrong fill or a wrong direction. Tap mode is tested on the top and bottom bits while match references are set to values the counter passes through, so tap and compare cannot be confused.

Stacked strobes (counter clear with load and event, load with event) separate the priority order. Load attempts while disabled show whether the enable gates the reference registers. A long seeded random run then mixes all controls against a cycle model of the counter, the references and the flags.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int CNT_W_DEF = 32;

    // Source of the next counter value, in decreasing priority.
    typedef enum logic [2:0] {
        SRC_HOLD  = 3'd0,
        SRC_CLEAR = 3'd1,
        SRC_EXT   = 3'd2,
        SRC_EVENT = 3'd3,
        SRC_COUNT = 3'd4
    } cnt_src_e;

    typedef struct packed {
        logic is_load;
        logic arith;
        logic dir;
    } evt_cfg_t;

    function automatic cnt_src_e pick_src(
        input logic clr,
        input logic en,
        input logic ld,
        input logic ev,
        input logic run
    );
        cnt_src_e s;
        if (clr)       s = SRC_CLEAR;
        else if (!en)  s = SRC_HOLD;
        else if (ld)   s = SRC_EXT;
        else if (ev)   s = SRC_EVENT;
        else if (run)  s = SRC_COUNT;
        else           s = SRC_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/evc_next_val.sv
module evc_next_val
    import evc_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic [W-1:0] cur,
    input  cnt_src_e     src,
    input  logic         up,
    input  evt_cfg_t     cfg,
    input  logic [W-1:0] evt_val,
    input  logic [W-1:0] ext_val,
    output logic [W-1:0] nxt
);

    logic [W-1:0] ev_res;
    logic [W-1:0] step_res;

    always_comb begin
        if (cfg.is_load)
            ev_res = evt_val;
        else if (cfg.arith)
            ev_res = cfg.dir ? (cur + evt_val) : (cur - evt_val);
        else
            ev_res = cfg.dir ? {cur[W-2:0], 1'b0} : {1'b0, cur[W-1:1]};
    end

    assign step_res = up ? (cur + W'(1)) : (cur - W'(1));

    always_comb begin
        unique case (src)
            SRC_CLEAR: nxt = '0;
            SRC_EXT:   nxt = ext_val;
            SRC_EVENT: nxt = ev_res;
            SRC_COUNT: nxt = step_res;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/evc_match_chan.sv
module evc_match_chan #(
    parameter int W  = 32,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          glb_en,
    input  logic          ld,
    input  logic [W-1:0]  ld_val,
    input  logic [W-1:0]  cnt,
    input  logic          tap_en,
    input  logic [IW-1:0] tap_idx,
    output logic          flag
);

    logic [W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= '0;
        else if (glb_en && ld)
            ref_q <= ld_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b1;
        else if (tap_en)
            flag <= cnt[tap_idx];
        else
            flag <= (cnt == ref_q);
    end

    // R7
    ref_load_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en && ld) |=> ref_q == $past(ld_val));

    // R12
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> $stable(ref_q));

    // R6
    tap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tap_en |=> flag == $past(cnt[tap_idx]));

    // R5
    cmp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !tap_en |=> flag == ($past(cnt) == $past(ref_q)));

endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evc_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cnt_rst,
    input  logic                 glb_en,
    input  logic                 run_en,
    input  logic                 count_up,
    input  logic                 evt,
    input  logic                 evt_is_load,
    input  logic                 evt_arith,
    input  logic                 evt_dir,
    input  logic [W-1:0]         evt_val,
    input  logic                 tap1_en,
    input  logic [$clog2(W)-1:0] tap1_idx,
    input  logic                 tap2_en,
    input  logic [$clog2(W)-1:0] tap2_idx,
    input  logic [W-1:0]         ext_val,
    input  logic                 ld_cnt,
    input  logic                 ld_m1,
    input  logic                 ld_m2,
    output logic [W-1:0]         cnt_val,
    output logic                 zero_flag,
    output logic                 m1_flag,
    output logic                 m2_flag
);

    localparam int IW  = $clog2(W);
    localparam int NCH = 2;

    evt_cfg_t     cfg;
    cnt_src_e     src;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    assign cfg = '{is_load: evt_is_load, arith: evt_arith, dir: evt_dir};
    assign src = pick_src(cnt_rst, glb_en, ld_cnt, evt, run_en);

    evc_next_val #(.W(W)) u_next (
        .cur     (cnt_q),
        .src     (src),
        .up      (count_up),
        .cfg     (cfg),
        .evt_val (evt_val),
        .ext_val (ext_val),
        .nxt     (cnt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        if (rst) zero_flag <= 1'b1;
        else     zero_flag <= (cnt_q == '0);
    end

    assign cnt_val = cnt_q;

    logic [NCH-1:0]         ch_ld;
    logic [NCH-1:0]         ch_tap_en;
    logic [NCH-1:0][IW-1:0] ch_idx;
    logic [NCH-1:0]         ch_flag;

    assign ch_ld     = {ld_m2, ld_m1};
    assign ch_tap_en = {tap2_en, tap1_en};
    assign ch_idx    = {tap2_idx, tap1_idx};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        evc_match_chan #(.W(W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .glb_en  (glb_en),
            .ld      (ch_ld[g]),
            .ld_val  (ext_val),
            .cnt     (cnt_q),
            .tap_en  (ch_tap_en[g]),
            .tap_idx (ch_idx[g]),
            .flag    (ch_flag[g])
        );
    end

    assign m1_flag = ch_flag[0];
    assign m2_flag = ch_flag[1];

    // R2
    count_up_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en && run_en && count_up && !cnt_rst && !ld_cnt && !evt)
        |=> cnt_val == W'($past(cnt_val) + W'(1)));

    // R3
    count_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en && run_en && !count_up && !cnt_rst && !ld_cnt && !evt)
        |=> cnt_val == W'($past(cnt_val) - W'(1)));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> zero_flag == ($past(cnt_val) == '0));

    // R7
    ext_load_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en && ld_cnt && !cnt_rst) |=> cnt_val == $past(ext_val));

    // R8
    evt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en && evt && evt_is_load && !ld_cnt && !cnt_rst)
        |=> cnt_val == $past(evt_val));

    // R11
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_rst |=> cnt_val == '0);

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!glb_en && !cnt_rst) |=> $stable(cnt_val));

endmodule

// File: tb/evt_counter_tb.sv
module evt_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1, cnt_rst = 1'b0, glb_en = 1'b0, run_en = 1'b0, count_up = 1'b0;
    logic evt = 1'b0, evt_is_load = 1'b0, evt_arith = 1'b0, evt_dir = 1'b0;
    logic [31:0] evt_val = '0, ext_val = '0;
    logic tap1_en = 1'b0, tap2_en = 1'b0;
    logic [4:0] tap1_idx = '0, tap2_idx = '0;
    logic ld_cnt = 1'b0, ld_m1 = 1'b0, ld_m2 = 1'b0;
    logic [31:0] cnt_val;
    logic zero_flag, m1_flag, m2_flag;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    logic [31:0] m_cnt = '0, m_r1 = '0, m_r2 = '0;
    logic m_z = 1'b1, m_f1 = 1'b1, m_f2 = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_counter u_dut (
        .clk(clk), .rst(rst), .cnt_rst(cnt_rst), .glb_en(glb_en), .run_en(run_en),
        .count_up(count_up), .evt(evt), .evt_is_load(evt_is_load), .evt_arith(evt_arith),
        .evt_dir(evt_dir), .evt_val(evt_val), .tap1_en(tap1_en), .tap1_idx(tap1_idx),
        .tap2_en(tap2_en), .tap2_idx(tap2_idx), .ext_val(ext_val), .ld_cnt(ld_cnt),
        .ld_m1(ld_m1), .ld_m2(ld_m2), .cnt_val(cnt_val), .zero_flag(zero_flag),
        .m1_flag(m1_flag), .m2_flag(m2_flag)
    );

    function automatic logic [31:0] ev_result(logic [31:0] c);
        if (evt_is_load)    return evt_val;
        if (evt_arith)      return evt_dir ? c + evt_val : c - evt_val;
        return evt_dir ? (c << 1) : (c >> 1);
    endfunction

    function automatic logic [31:0] model_next(logic [31:0] c);
        if (cnt_rst)     return 32'h0;
        if (!glb_en)     return c;
        if (ld_cnt)      return ext_val;
        if (evt)         return ev_result(c);
        if (run_en)      return count_up ? c + 32'd1 : c - 32'd1;
        return c;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        rst = 0; cnt_rst = 0; glb_en = 1; run_en = 0; count_up = 0;
        evt = 0; evt_is_load = 0; evt_arith = 0; evt_dir = 0;
        ld_cnt = 0; ld_m1 = 0; ld_m2 = 0;
    endtask

    task automatic step(string tag);
        logic [31:0] nc, n1r, n2r;
        logic nz, nf1, nf2;
        if (rst) begin
            nc = 0; n1r = 0; n2r = 0; nz = 1; nf1 = 1; nf2 = 1;
        end else begin
            nz  = (m_cnt == 0);
            nf1 = tap1_en ? m_cnt[tap1_idx] : (m_cnt == m_r1);
            nf2 = tap2_en ? m_cnt[tap2_idx] : (m_cnt == m_r2);
            n1r = (glb_en && ld_m1) ? ext_val : m_r1;
            n2r = (glb_en && ld_m2) ? ext_val : m_r2;
            nc  = model_next(m_cnt);
        end
        @(posedge clk);
        @(negedge clk);
        m_cnt = nc; m_r1 = n1r; m_r2 = n2r; m_z = nz; m_f1 = nf1; m_f2 = nf2;
        chk(tag, "cnt_val", cnt_val, m_cnt);
        chk(tag, "zero_flag", {31'b0, zero_flag}, {31'b0, m_z});
        chk(tag, "m1_flag", {31'b0, m1_flag}, {31'b0, m_f1});
        chk(tag, "m2_flag", {31'b0, m2_flag}, {31'b0, m_f2});
    endtask

    initial begin
        while (!done && cyc < WD_LIMIT) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state
        rst = 1;
        step("R1");
        chk("R1", "cnt_val", cnt_val, 32'h0);
        chk("R1", "flags", {29'b0, zero_flag, m1_flag, m2_flag}, 32'h7);
        idle();

        // R7: load counter and match ref 1 together, ref 2 separately
        ext_val = 32'hFFFF_FFFE; ld_cnt = 1; ld_m1 = 1;
        step("R7");
        idle(); ext_val = 32'h0000_0003; ld_m2 = 1;
        step("R7");
        idle();
        step("R5");

        // R2: count up through the wrap point
        run_en = 1; count_up = 1;
        repeat (4) step("R2");
        // R4: zero flag seen after wrap
        run_en = 0;
        step("R4");
        repeat (2) step("R2");

        // R3: count down through zero
        ext_val = 32'h1; ld_cnt = 1; step("R7");
        ld_cnt = 0; run_en = 1; count_up = 0;
        repeat (3) step("R3");

        // R6: taps on top and bottom bits while counting down
        tap1_en = 1; tap1_idx = 5'd31; tap2_en = 1; tap2_idx = 5'd0;
        repeat (3) step("R6");
        tap1_en = 0; tap2_en = 0;

        // R8: event load replaces counting
        evt = 1; evt_is_load = 1; evt_val = 32'h0000_1234;
        step("R8");
        evt = 0; run_en = 0;
        evt = 1; evt_val = 32'hDEAD_BEEF; step("R8");
        evt = 0; evt_is_load = 0;

        // R9: add and subtract with wrap
        ext_val = 32'hFFFF_FFF0; ld_cnt = 1; step("R7"); ld_cnt = 0;
        evt = 1; evt_arith = 1; evt_dir = 1; evt_val = 32'h20; step("R9");
        evt_dir = 0; evt_val = 32'h30; step("R9");
        evt = 0; evt_arith = 0;

        // R10: shifts drop a set bit at each end
        ext_val = 32'h8000_0001; ld_cnt = 1; step("R7"); ld_cnt = 0;
        evt = 1; evt_dir = 1; step("R10");
        ext_val = 32'h8000_0001; ld_cnt = 1; evt = 0; step("R7"); ld_cnt = 0;
        evt = 1; evt_dir = 0; step("R10");
        step("R10");
        evt = 0;

        // R11: priority stack
        run_en = 1; count_up = 1;
        cnt_rst = 1; ld_cnt = 1; ext_val = 32'h77; evt = 1; evt_is_load = 1; evt_val = 32'h99;
        step("R11");
        cnt_rst = 0;
        step("R11");
        ld_cnt = 0;
        step("R11");
        evt = 0; evt_is_load = 0;
        step("R11");

        // R12: disabled block ignores strobes, event and counting
        ext_val = 32'h55; ld_cnt = 1; step("R7"); ld_cnt = 0;
        glb_en = 0; ld_cnt = 1; ld_m2 = 1; ld_m1 = 1; ext_val = 32'h0000_0055;
        evt = 1; evt_val = 32'h1;
        repeat (2) step("R12");
        idle();
        repeat (2) step("R12");
        glb_en = 0; cnt_rst = 1; step("R12");
        idle();

        // R11: seeded random mix against the model
        for (int i = 0; i < 3000; i++) begin
            rst         = ($urandom % 200) == 0;
            cnt_rst     = ($urandom % 16) == 0;
            glb_en      = ($urandom % 8) != 0;
            run_en      = ($urandom % 4) != 0;
            count_up    = $urandom % 2;
            evt         = ($urandom % 4) == 0;
            evt_is_load = $urandom % 2;
            evt_arith   = $urandom % 2;
            evt_dir     = $urandom % 2;
            evt_val     = ($urandom % 2) ? $urandom : ($urandom % 8);
            ld_cnt      = ($urandom % 8) == 0;
            ld_m1       = ($urandom % 8) == 0;
            ld_m2       = ($urandom % 8) == 0;
            ext_val     = ($urandom % 2) ? $urandom : ($urandom % 8);
            tap1_en     = ($urandom % 3) == 0;
            tap2_en     = ($urandom % 3) == 0;
            tap1_idx    = 5'($urandom);
            tap2_idx    = 5'($urandom);
            step("R11");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule